// File: doc/BRIEF.md
# Waveform-RAM Block Generator

This block plays a stored waveform out as a stream of framed packets. A small RAM holds complex sample words, with the real part in the low half and the imaginary part in the high half. Software loads this RAM through a dedicated write port. Software then programs a handful of registers and sets the enable bit.

While the block is enabled, it walks a programmed window of the RAM one word per cycle. It cuts the output into packets of a programmed length and can insert idle cycles between packets. Every packet carries a start marker and an end marker. Every packet also carries a sequence number, which counts up from a programmed starting value. A sync flag marks the first packet of each group of packets.

The group size can be retuned while the block runs, which forces a sync earlier or later than the current schedule. Every other setting is captured when the block starts. When enable is cleared, the block stops cleanly at a packet boundary.

Top module: `wave_block_gen`

## Requirements
- R1: After reset, outValid, outSop, outEop and outSync are low, and no sample is emitted until the enable bit is set.
- R2: A write on the RAM port stores ramWrData at ramWrAddr. Each emitted outData equals the RAM word at the current read address. Bits [SAMPLE_W-1:0] hold the real part and bits [2*SAMPLE_W-1:SAMPLE_W] hold the imaginary part.
- R3: A packet is pktLen consecutive valid beats. outSop is high on the first beat and outEop on the last; with pktLen 1, both are high on the single beat.
- R4: The read address starts at the low bound when the block starts and advances by one per beat. After the high bound it returns to the low bound, and it runs on across packet boundaries.
- R5: Exactly gapLen idle cycles separate the last beat of one packet from the first beat of the next; gapLen 0 gives back-to-back packets.
- R6: The first packet after start carries the initial sequence number. Each later packet carries the previous value plus one, modulo 2^REG_W, and outSeq stays constant across all beats of a packet.
- R7: outSync is high only on the first beat of a packet. It marks the first packet after start and then every syncBlocks-th packet; syncBlocks 0 acts as 1.
- R8: A write to syncBlocks while running takes effect at once: the packet count since the last sync is compared with the new value, so later syncs fall at the new spacing.
- R9: Packet length, gap, RAM bounds and initial sequence number are captured when the block starts. Writing them while it runs does not change the output until the next start.
- R10: Clearing enable lets the current packet finish in full, then stops output. A later enable restarts at the low bound with the initial sequence number and a sync.
- R11: Register offsets on regAddr: 0 control (bit 0 enable), 1 pktLen, 2 syncBlocks, 3 gapLen, 4 low bound, 5 high bound, 6 initial sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWrData | input | REG_W | Register write value |
| ramWrEn | input | 1 | Waveform RAM write strobe |
| ramWrAddr | input | ADDR_W | Waveform RAM write address |
| ramWrData | input | 2*SAMPLE_W | Waveform word, imaginary in the high half, real in the low half |
| outValid | output | 1 | Output beat valid |
| outData | output | 2*SAMPLE_W | Output sample word |
| outSop | output | 1 | First beat of a packet |
| outEop | output | 1 | Last beat of a packet |
| outSync | output | 1 | Packet opens a sync group |
| outSeq | output | REG_W | Packet sequence number |

## Verification
A slip in the read address shows up as wrong outData on the very next beat, because every word is tagged with its own address. A wrong sample counter shows up as a misplaced outEop or outSop within one packet. A wrong gap counter changes the idle spacing before the next outSop. A wrong group counter moves outSync, and the moved sync is seen at the next packet start, or at most one group of packets later after a live retune. A wrong stop condition shows up as a packet that ends without outEop, or as output that continues after enable is cleared.

// File: rtl/wbg_pkg.sv
package wbg_pkg;
  localparam logic [2:0] REG_CTRL    = 3'd0;
  localparam logic [2:0] REG_PKTLEN  = 3'd1;
  localparam logic [2:0] REG_SYNCBLK = 3'd2;
  localparam logic [2:0] REG_GAP     = 3'd3;
  localparam logic [2:0] REG_LO      = 3'd4;
  localparam logic [2:0] REG_HI      = 3'd5;
  localparam logic [2:0] REG_SEQ     = 3'd6;

  typedef struct packed {
    logic emit;
    logic sop;
    logic eop;
    logic sync;
  } wbg_strobe_t;
endpackage

// File: rtl/wbg_regs.sv
module wbg_regs #(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic              enable,
  output logic [REG_W-1:0]  pktLen,
  output logic [REG_W-1:0]  syncBlocks,
  output logic [REG_W-1:0]  gapLen,
  output logic [ADDR_W-1:0] ramLo,
  output logic [ADDR_W-1:0] ramHi,
  output logic [REG_W-1:0]  seqInit
);
  import wbg_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable     <= 1'b0;
      pktLen     <= REG_W'(1);
      syncBlocks <= REG_W'(1);
      gapLen     <= '0;
      ramLo      <= '0;
      ramHi      <= '1;
      seqInit    <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        REG_CTRL:    enable     <= regWrData[0];
        REG_PKTLEN:  pktLen     <= regWrData;
        REG_SYNCBLK: syncBlocks <= regWrData;
        REG_GAP:     gapLen     <= regWrData;
        REG_LO:      ramLo      <= regWrData[ADDR_W-1:0];
        REG_HI:      ramHi      <= regWrData[ADDR_W-1:0];
        REG_SEQ:     seqInit    <= regWrData;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wbg_ctrl.sv
module wbg_ctrl #(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [REG_W-1:0]   pktLen,
  input  logic [REG_W-1:0]   syncBlocks,
  input  logic [REG_W-1:0]   gapLen,
  input  logic [ADDR_W-1:0]  ramLo,
  input  logic [ADDR_W-1:0]  ramHi,
  input  logic [REG_W-1:0]   seqInit,
  output wbg_pkg::wbg_strobe_t strb,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [REG_W-1:0]   seqNum
);
  logic              running, inGap;
  logic [REG_W-1:0]  lenAct, gapAct, sampCnt, gapCnt, blkCnt;
  logic [ADDR_W-1:0] loAct, hiAct;
  logic [REG_W:0]    sampNext, gapNext, blkNext;
  logic              lastSamp, gapDone, groupDone;

  assign sampNext  = {1'b0, sampCnt} + 1'b1;
  assign gapNext   = {1'b0, gapCnt} + 1'b1;
  assign blkNext   = {1'b0, blkCnt} + 1'b1;
  assign lastSamp  = sampNext >= {1'b0, lenAct};
  assign gapDone   = gapNext >= {1'b0, gapAct};
  assign groupDone = blkNext >= {1'b0, syncBlocks};

  always_comb begin
    strb.emit = running && !inGap;
    strb.sop  = strb.emit && (sampCnt == '0);
    strb.eop  = strb.emit && lastSamp;
    strb.sync = strb.sop && (blkCnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      inGap   <= 1'b0;
      lenAct  <= '0;
      gapAct  <= '0;
      loAct   <= '0;
      hiAct   <= '0;
      sampCnt <= '0;
      gapCnt  <= '0;
      blkCnt  <= '0;
      rdAddr  <= '0;
      seqNum  <= '0;
    end else if (!running) begin
      if (enable) begin
        running <= 1'b1;
        inGap   <= 1'b0;
        lenAct  <= pktLen;
        gapAct  <= gapLen;
        loAct   <= ramLo;
        hiAct   <= ramHi;
        rdAddr  <= ramLo;
        seqNum  <= seqInit;
        sampCnt <= '0;
        blkCnt  <= '0;
      end
    end else if (inGap) begin
      if (!enable) begin
        running <= 1'b0;
        inGap   <= 1'b0;
      end else if (gapDone) begin
        inGap  <= 1'b0;
        gapCnt <= '0;
      end else begin
        gapCnt <= gapNext[REG_W-1:0];
      end
    end else begin
      rdAddr <= (rdAddr == hiAct) ? loAct : rdAddr + 1'b1;
      if (lastSamp) begin
        sampCnt <= '0;
        seqNum  <= seqNum + 1'b1;
        blkCnt  <= groupDone ? '0 : blkNext[REG_W-1:0];
        if (!enable) begin
          running <= 1'b0;
        end else if (gapAct != '0) begin
          inGap  <= 1'b1;
          gapCnt <= '0;
        end
      end else begin
        sampCnt <= sampNext[REG_W-1:0];
      end
    end
  end
endmodule

// File: rtl/wbg_datapath.sv
module wbg_datapath #(
  parameter int SAMPLE_W = 8,
  parameter int ADDR_W   = 8,
  parameter int REG_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ramWrEn,
  input  logic [ADDR_W-1:0]     ramWrAddr,
  input  logic [2*SAMPLE_W-1:0] ramWrData,
  input  wbg_pkg::wbg_strobe_t  strb,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [REG_W-1:0]      seqNum,
  output logic                  outValid,
  output logic [2*SAMPLE_W-1:0] outData,
  output logic                  outSop,
  output logic                  outEop,
  output logic                  outSync,
  output logic [REG_W-1:0]      outSeq
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = 2 * SAMPLE_W;

  logic [WORD_W-1:0] waveMem [DEPTH];

  always_ff @(posedge clk) begin
    if (ramWrEn) waveMem[ramWrAddr] <= ramWrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
      outSync  <= 1'b0;
      outData  <= '0;
      outSeq   <= '0;
    end else begin
      outValid <= strb.emit;
      outSop   <= strb.sop;
      outEop   <= strb.eop;
      outSync  <= strb.sync;
      outData  <= strb.emit ? waveMem[rdAddr] : '0;
      if (strb.emit) outSeq <= seqNum;
    end
  end
endmodule

// File: rtl/wave_block_gen.sv
module wave_block_gen #(
  parameter int SAMPLE_W = 8,
  parameter int ADDR_W   = 8,
  parameter int REG_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  regWrEn,
  input  logic [2:0]            regAddr,
  input  logic [REG_W-1:0]      regWrData,
  input  logic                  ramWrEn,
  input  logic [ADDR_W-1:0]     ramWrAddr,
  input  logic [2*SAMPLE_W-1:0] ramWrData,
  output logic                  outValid,
  output logic [2*SAMPLE_W-1:0] outData,
  output logic                  outSop,
  output logic                  outEop,
  output logic                  outSync,
  output logic [REG_W-1:0]      outSeq
);
  logic              enable;
  logic [REG_W-1:0]  pktLen, syncBlocks, gapLen, seqInit, seqNum;
  logic [ADDR_W-1:0] ramLo, ramHi, rdAddr;
  wbg_pkg::wbg_strobe_t strb;

  wbg_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .enable(enable), .pktLen(pktLen),
    .syncBlocks(syncBlocks), .gapLen(gapLen), .ramLo(ramLo),
    .ramHi(ramHi), .seqInit(seqInit)
  );

  wbg_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pktLen(pktLen),
    .syncBlocks(syncBlocks), .gapLen(gapLen), .ramLo(ramLo),
    .ramHi(ramHi), .seqInit(seqInit), .strb(strb), .rdAddr(rdAddr),
    .seqNum(seqNum)
  );

  wbg_datapath #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr),
    .ramWrData(ramWrData), .strb(strb), .rdAddr(rdAddr), .seqNum(seqNum),
    .outValid(outValid), .outData(outData), .outSop(outSop),
    .outEop(outEop), .outSync(outSync), .outSeq(outSeq)
  );
endmodule

// File: rtl/wbg_checker.sv
module wbg_checker #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             outValid,
  input logic             outSop,
  input logic             outEop,
  input logic             outSync,
  input logic [REG_W-1:0] outSeq
);
  logic             inPkt;
  logic [REG_W-1:0] lastSeq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inPkt   <= 1'b0;
      lastSeq <= '0;
    end else if (outValid) begin
      lastSeq <= outSeq;
      if (outEop) inPkt <= 1'b0;
      else if (outSop) inPkt <= 1'b1;
    end
  end

  assert_marks_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (outSop || outEop) |-> outValid);
  assert_sop_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !inPkt) |-> outSop);
  assert_no_sop_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inPkt |-> !outSop);
  assert_no_truncation_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inPkt |-> outValid);
  assert_seq_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && inPkt) |-> (outSeq == lastSeq));
  assert_sync_on_sop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    outSync |-> outSop);
endmodule

bind wave_block_gen wbg_checker #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .outValid(outValid), .outSop(outSop),
  .outEop(outEop), .outSync(outSync), .outSeq(outSeq)
);

// File: tb/sim_wave_block_gen.sv
module sim_wave_block_gen;
  localparam int SW = 8;
  localparam int AW = 8;
  localparam int RW = 16;
  localparam int LOGN = 4096;
  localparam int NBEATS = 24;
  // pktLen, syncBlocks, gapLen, lo, hi, seqInit
  localparam int VEC [4][6] = '{
    '{4, 2, 0,   0,   9,    10},
    '{5, 3, 2,  20,  26,   100},
    '{1, 1, 1,   3,   5,     0},
    '{8, 0, 3, 250, 255, 65530}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [RW-1:0] regWrData = '0;
  logic ramWrEn = 1'b0;
  logic [AW-1:0] ramWrAddr = '0;
  logic [2*SW-1:0] ramWrData = '0;
  logic outValid, outSop, outEop, outSync;
  logic [2*SW-1:0] outData;
  logic [RW-1:0] outSeq;

  always #2 clk = ~clk;

  wave_block_gen #(.SAMPLE_W(SW), .ADDR_W(AW), .REG_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr),
    .ramWrData(ramWrData), .outValid(outValid), .outData(outData),
    .outSop(outSop), .outEop(outEop), .outSync(outSync), .outSeq(outSeq)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int capN = 0;
  bit done = 0;
  logic [2*SW-1:0] lData [LOGN];
  logic [RW-1:0]   lSeq  [LOGN];
  bit              lSop  [LOGN];
  bit              lEop  [LOGN];
  bit              lSync [LOGN];
  int              lCyc  [LOGN];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && outValid && capN < LOGN) begin
      lData[capN] = outData;
      lSeq[capN]  = outSeq;
      lSop[capN]  = outSop;
      lEop[capN]  = outEop;
      lSync[capN] = outSync;
      lCyc[capN]  = cyc;
      capN = capN + 1;
    end
  end

  function automatic logic [2*SW-1:0] ramVal(input int a);
    logic [7:0] lo8;
    lo8 = 8'(a);
    return {lo8 ^ 8'hC3, lo8};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input int d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = RW'(d);
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic configure(input int len, input int sb, input int gap,
                           input int lo, input int hi, input int seq);
    regWrite(3'd1, len);
    regWrite(3'd2, sb);
    regWrite(3'd3, gap);
    regWrite(3'd4, lo);
    regWrite(3'd5, hi);
    regWrite(3'd6, seq);
  endtask

  task automatic stopGen();
    regWrite(3'd0, 0);
    repeat (60) @(posedge clk);
  endtask

  task automatic waitBeats(input int target);
    while (capN < target) @(posedge clk);
  endtask

  function automatic int lastSyncGap();
    int s1 = -1;
    int s2 = -1;
    for (int i = capN - 1; i >= 0; i--) begin
      if (lSync[i]) begin
        if (s1 < 0) s1 = int'(lSeq[i]);
        else begin s2 = int'(lSeq[i]); break; end
      end
    end
    return (s1 - s2) & 16'hFFFF;
  endfunction

  task automatic verifyRun(input int st, input int len, input int sb, input int gap,
                           input int lo, input int hi, input int seq);
    int addr = lo;
    int sbE = (sb == 0) ? 1 : sb;
    bit okD = 1, okF = 1, okS = 1, okY = 1, okG = 1;
    int aD = 0, eD = 0, aS = 0, eS = 0, aG = 0, eG = 0;
    for (int b = 0; b < NBEATS; b++) begin
      int p = b / len;
      int i = b % len;
      int idx = st + b;
      bit eSop = (i == 0);
      bit eEop = (i == len - 1);
      bit eSync = eSop && (p % sbE == 0);
      int eSeq = (seq + p) & 16'hFFFF;
      if (okD && lData[idx] != ramVal(addr)) begin okD = 0; aD = int'(lData[idx]); eD = int'(ramVal(addr)); end
      if (lSop[idx] != eSop || lEop[idx] != eEop) okF = 0;
      if (lSync[idx] != eSync) okY = 0;
      if (okS && int'(lSeq[idx]) != eSeq) begin okS = 0; aS = int'(lSeq[idx]); eS = eSeq; end
      if (b > 0 && okG) begin
        int expDiff = eSop ? gap + 1 : 1;
        if (lCyc[idx] - lCyc[idx-1] != expDiff) begin okG = 0; aG = lCyc[idx] - lCyc[idx-1]; eG = expDiff; end
      end
      addr = (addr == hi) ? lo : addr + 1;
    end
    check(okD, "R2/R4 sample word at read address", aD, eD);
    check(okF, "R3/R9 packet markers at captured length", 0, 1);
    check(okG, "R5 idle spacing", aG, eG);
    check(okS, "R6/R11 sequence number", aS, eS);
    check(okY, "R7 sync placement", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R1: quiet after reset with enable clear
    check(!outValid && !outSop && !outEop && !outSync, "R1 outputs idle after reset",
          int'({outValid, outSop, outEop, outSync}), 0);
    check(capN == 0, "R1 no beats before enable", capN, 0);

    for (int a = 0; a < (1 << AW); a++) begin
      @(posedge clk); #1;
      ramWrEn = 1'b1; ramWrAddr = AW'(a); ramWrData = ramVal(a);
    end
    @(posedge clk); #1 ramWrEn = 1'b0;
    repeat (5) @(negedge clk);
    check(capN == 0, "R1 no beats while RAM loads", capN, 0);

    for (int v = 0; v < 4; v++) begin
      int st;
      stopGen();
      st = capN;
      configure(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
      regWrite(3'd0, 1);
      repeat (8) @(posedge clk);
      // R9: these writes must not alter the running stream
      regWrite(3'd1, VEC[v][0] + 3);
      regWrite(3'd3, VEC[v][2] + 2);
      waitBeats(st + NBEATS);
      verifyRun(st, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
    end

    // R10: stop mid-packet, then restart
    begin
      int st, n, s2;
      stopGen();
      configure(6, 2, 2, 0, 255, 500);
      st = capN;
      regWrite(3'd0, 1);
      waitBeats(st + 8);
      regWrite(3'd0, 0);
      repeat (40) @(posedge clk);
      @(negedge clk);
      n = capN - st;
      check(n % 6 == 0 && n >= 12, "R10 only whole packets after disable", n, 12);
      check(lEop[capN-1], "R10 last beat closes packet", int'(lEop[capN-1]), 1);
      check(!outValid, "R10 output stopped", int'(outValid), 0);
      s2 = capN;
      regWrite(3'd0, 1);
      waitBeats(s2 + 1);
      check(lSop[s2] && lSync[s2], "R10 restart opens with sop and sync",
            int'({lSop[s2], lSync[s2]}), 3);
      check(lSeq[s2] == 16'd500, "R10 restart seq", int'(lSeq[s2]), 500);
      check(lData[s2] == ramVal(0), "R10 restart at low bound", int'(lData[s2]), int'(ramVal(0)));
    end

    // R8: live retune of syncBlocks
    begin
      int st;
      stopGen();
      configure(2, 3, 0, 0, 255, 0);
      st = capN;
      regWrite(3'd0, 1);
      waitBeats(st + 20);
      @(negedge clk);
      check(lastSyncGap() == 3, "R8 initial sync spacing", lastSyncGap(), 3);
      regWrite(3'd2, 2);
      repeat (40) @(posedge clk);
      @(negedge clk);
      check(lastSyncGap() == 2, "R8 early sync spacing", lastSyncGap(), 2);
      regWrite(3'd2, 5);
      repeat (60) @(posedge clk);
      @(negedge clk);
      check(lastSyncGap() == 5, "R8 late sync spacing", lastSyncGap(), 5);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule